// File: doc/BRIEF.md
# Round-Robin Arbiter for a Shared Bus Subordinate

This block decides which of several bus managers may drive one shared subordinate. Each cycle it looks at every manager's select line for that subordinate and its transfer type, and it qualifies a request only for a non-sequential transfer. The qualified requests are rotated by a priority pointer and resolved by a lowest-index-wins priority chain. The result is rotated back into a one-hot address-phase grant, and a system mux uses that grant to route the winning manager's address and control to the subordinate. The grant is combinational, so a request that arrives in a cycle can be granted in that same cycle.

A second one-hot vector, the data-phase owner, is a copy of the grant. It is registered only in cycles where the subordinate's ready input is high, and it marks whose data phase is in flight. The owner steers the ready signals. The subordinate's ready output goes back only to the owning manager, and it also goes into the subordinate's own ready input. With no owner, every manager and the subordinate see ready high, so the bus cannot deadlock. After each accepted grant the priority pointer moves to the manager just after the winner. This bounds the wait of any requester. The rotation works for any manager count, powers of two or not.

Top module: `rr_bus_arbiter`

## Requirements
- R1: A manager requests only when its select bit is 1 and its 2-bit transfer field (bits 2i+1:2i of `mgr_trans`) equals 2'b10 (non-sequential). The codes 2'b00 (idle), 2'b01 and 2'b11 never request.
- R2: `grant` is always one-hot or zero and has bits only where a request exists. It is non-zero in the same cycle that any request is present.
- R3: With pointer value p, the grant goes to the first requesting manager found scanning p, p+1, … cyclically modulo NUM_MGR.
- R4: When `sub_ready_in` is high and `grant` is non-zero at a clock edge, the pointer becomes (winner+1) mod NUM_MGR. Otherwise it holds.
- R5: A manager that keeps requesting is passed over by at most NUM_MGR-1 accepted grants to other managers before it is granted.
- R6: `grant_owner` takes the value of `grant` at each clock edge where `sub_ready_in` is high, and holds its value otherwise.
- R7: `mgr_ready[i]` equals `sub_ready_out` when `grant_owner[i]` is 1, equals 0 when another manager owns the data phase, and is 1 for every manager when `grant_owner` is zero.
- R8: `sub_ready_in` equals `sub_ready_out` while some manager owns the data phase, and is 1 when `grant_owner` is zero.
- R9: Reset (`rst_n` low, asynchronous) clears `grant_owner` to zero and sets the pointer to manager 0.
- R10: With a non-power-of-two manager count (default 5), the rotation and the wrap from the last manager to manager 0 behave per R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| mgr_sel | input | NUM_MGR | Per-manager decode select for this subordinate |
| mgr_trans | input | 2*NUM_MGR | Per-manager transfer type, manager i in bits 2i+1:2i |
| sub_ready_out | input | 1 | Ready output of the subordinate |
| grant | output | NUM_MGR | One-hot address-phase grant (combinational) |
| grant_owner | output | NUM_MGR | One-hot data-phase owner (registered) |
| sub_ready_in | output | 1 | Ready driven into the subordinate |
| mgr_ready | output | NUM_MGR | Ready returned to each manager |

## Verification
The assertions check the cycle-local properties on every clock. These are the one-hot grant, a grant only where a request exists, the owner loading on ready and holding otherwise, the pointer holding when no grant is accepted, and all-ready when nothing is owned. Only the directed scenarios can show the fairness bound over a stream of grants, the cyclic priority order after particular pointer moves, the wrap from the last manager, and the rejection of each non-qualifying transfer code. The bench checks these against its own pointer and owner model.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  // Transfer-type encoding on the bus
  typedef enum logic [1:0] {
    XFER_IDLE   = 2'b00,
    XFER_BUSY   = 2'b01,
    XFER_NONSEQ = 2'b10,
    XFER_SEQ    = 2'b11
  } xfer_e;

  localparam int XFER_W = 2;
endpackage

// File: rtl/rr_rotator.sv
// Rotates a vector by a run-time amount, for any width.
// TOWARD_ZERO=1: out[j] = in[(j+amt) mod W]; 0: out[j] = in[(j-amt) mod W].
module rr_rotator #(
  parameter int W           = 5,
  parameter bit TOWARD_ZERO = 1'b1,
  localparam int AW         = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  generate
    if (TOWARD_ZERO) begin : g_down
      always_comb begin
        dout = '0;
        for (int s = 0; s < W; s++) begin
          if (amt == AW'(s)) begin
            for (int j = 0; j < W; j++) dout[j] = din[(j + s) % W];
          end
        end
      end
    end else begin : g_up
      always_comb begin
        dout = '0;
        for (int s = 0; s < W; s++) begin
          if (amt == AW'(s)) begin
            for (int j = 0; j < W; j++) dout[j] = din[(j + W - s) % W];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rr_fixed_prio.sv
// Lowest index wins; any set bit suppresses every higher-index bit.
module rr_fixed_prio #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] gnt
);
  logic [W-1:0] blocked;

  assign blocked[0] = 1'b0;
  generate
    for (genvar i = 1; i < W; i++) begin : g_chain
      assign blocked[i] = blocked[i-1] | req[i-1];
    end
  endgenerate

  assign gnt = req & ~blocked;
endmodule

// File: rtl/rr_ready_steer.sv
// Steers subordinate ready back to managers and into the subordinate.
module rr_ready_steer #(
  parameter int W = 5
) (
  input  logic [W-1:0] owner,
  input  logic         sub_ready_out,
  output logic         sub_ready_in,
  output logic [W-1:0] mgr_ready
);
  logic none_owned;

  assign none_owned   = (owner == '0);
  assign sub_ready_in = none_owned | sub_ready_out;

  generate
    for (genvar i = 0; i < W; i++) begin : g_ret
      assign mgr_ready[i] = none_owned | (owner[i] & sub_ready_out);
    end
  endgenerate
endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter
  import rr_arb_pkg::*;
#(
  parameter int NUM_MGR = 5,
  localparam int PW     = (NUM_MGR > 1) ? $clog2(NUM_MGR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_MGR-1:0]        mgr_sel,
  input  logic [XFER_W*NUM_MGR-1:0] mgr_trans,
  input  logic                      sub_ready_out,
  output logic [NUM_MGR-1:0]        grant,
  output logic [NUM_MGR-1:0]        grant_owner,
  output logic                      sub_ready_in,
  output logic [NUM_MGR-1:0]        mgr_ready
);
  localparam logic [PW-1:0] LAST_IDX = PW'(NUM_MGR - 1);

  logic [NUM_MGR-1:0] req;
  logic [NUM_MGR-1:0] req_rot;
  logic [NUM_MGR-1:0] gnt_rot;
  logic [PW-1:0]      ptr_q, ptr_d;
  logic [NUM_MGR-1:0] owner_q, owner_d;
  logic [PW-1:0]      win_idx;
  logic               accept;

  // Request qualification
  generate
    for (genvar i = 0; i < NUM_MGR; i++) begin : g_req
      assign req[i] = mgr_sel[i] &
                      (mgr_trans[XFER_W*i +: XFER_W] == XFER_NONSEQ);
    end
  endgenerate

  // Rotate -> fixed priority -> rotate back
  rr_rotator #(.W(NUM_MGR), .TOWARD_ZERO(1'b1)) u_rot_in (
    .din (req),
    .amt (ptr_q),
    .dout(req_rot)
  );

  rr_fixed_prio #(.W(NUM_MGR)) u_prio (
    .req(req_rot),
    .gnt(gnt_rot)
  );

  rr_rotator #(.W(NUM_MGR), .TOWARD_ZERO(1'b0)) u_rot_out (
    .din (gnt_rot),
    .amt (ptr_q),
    .dout(grant)
  );

  // Winner index from one-hot grant
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_MGR; i++) begin
      if (grant[i]) win_idx = PW'(i);
    end
  end

  assign accept = sub_ready_in & (grant != '0);

  // Next state
  always_comb begin
    ptr_d   = ptr_q;
    owner_d = owner_q;
    if (sub_ready_in) owner_d = grant;
    if (accept) ptr_d = (win_idx == LAST_IDX) ? '0 : win_idx + PW'(1);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      owner_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      owner_q <= owner_d;
    end
  end

  assign grant_owner = owner_q;

  rr_ready_steer #(.W(NUM_MGR)) u_steer (
    .owner        (owner_q),
    .sub_ready_out(sub_ready_out),
    .sub_ready_in (sub_ready_in),
    .mgr_ready    (mgr_ready)
  );

  // Assertions
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  a_r2_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));

  a_r6_owner_load: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ready_in |=> (grant_owner == $past(grant)));

  a_r6_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_ready_in |=> $stable(grant_owner));

  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_ready_in && (grant != '0)) |=> $stable(ptr_q));

  a_r7_all_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_owner == '0) |-> (&mgr_ready));

  a_r7_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_owner != '0) |-> $onehot0(mgr_ready));

  a_r8_sub_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_owner == '0) |-> sub_ready_in);
endmodule

// File: tb/rr_bus_arbiter_tb.sv
`timescale 1ns/1ps
module rr_bus_arbiter_tb;
  localparam int N = 5;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   mgr_sel;
  logic [2*N-1:0] mgr_trans;
  logic           sub_ready_out;
  logic [N-1:0]   grant;
  logic [N-1:0]   grant_owner;
  logic           sub_ready_in;
  logic [N-1:0]   mgr_ready;

  int checks;
  int errors;
  bit done;

  // bench model state
  int           ptr_m;
  logic [N-1:0] own_m;

  rr_bus_arbiter #(.NUM_MGR(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mgr_sel      (mgr_sel),
    .mgr_trans    (mgr_trans),
    .sub_ready_out(sub_ready_out),
    .grant        (grant),
    .grant_owner  (grant_owner),
    .sub_ready_in (sub_ready_in),
    .mgr_ready    (mgr_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] all_trans(input logic [1:0] code);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = code;
    return v;
  endfunction

  function automatic logic [N-1:0] model_req(input logic [N-1:0] s, input logic [2*N-1:0] t);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[i] && (t[2*i +: 2] == 2'b10);
    return r;
  endfunction

  function automatic logic [N-1:0] model_grant(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      if (r[(p + k) % N]) return N'(1) << ((p + k) % N);
    end
    return '0;
  endfunction

  // One cycle: drive at negedge, check combinational outputs, advance model at posedge
  task automatic step(input logic [N-1:0] s, input logic [2*N-1:0] t, input logic rdy,
                      input string tag, output logic [N-1:0] g_seen);
    logic [N-1:0] eg;
    logic         esri;
    logic [N-1:0] emr;
    @(negedge clk);
    mgr_sel       = s;
    mgr_trans     = t;
    sub_ready_out = rdy;
    #0.5;
    eg   = model_grant(model_req(s, t), ptr_m);
    esri = (own_m == '0) ? 1'b1 : rdy;
    emr  = (own_m == '0) ? '1 : (rdy ? own_m : '0);
    check({tag, " grant"}, 32'(grant), 32'(eg));
    check({tag, " R6 owner"}, 32'(grant_owner), 32'(own_m));
    check({tag, " R8 sub_ready_in"}, 32'(sub_ready_in), 32'(esri));
    check({tag, " R7 mgr_ready"}, 32'(mgr_ready), 32'(emr));
    g_seen = eg;
    @(posedge clk);
    if (esri) begin
      own_m = eg;
      for (int i = 0; i < N; i++) if (eg[i]) ptr_m = (i + 1) % N;
    end
  endtask

  task automatic t_reset;
    logic [N-1:0] g;
    rst_n = 1'b0;
    mgr_sel = '0; mgr_trans = '0; sub_ready_out = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 owner in reset", 32'(grant_owner), 32'h0);
    check("R9 mgr_ready in reset", 32'(mgr_ready), 32'((1 << N) - 1));
    rst_n = 1'b1;
    ptr_m = 0; own_m = '0;
    // all request: pointer 0 must pick manager 0
    step('1, all_trans(2'b10), 1'b1, "R9", g);
    check("R9 first grant is manager 0", 32'(g), 32'h1);
    step('0, all_trans(2'b00), 1'b1, "R9", g);
    step('0, all_trans(2'b00), 1'b1, "R9", g);
  endtask

  task automatic t_qualify;
    logic [N-1:0] g;
    logic [2*N-1:0] t;
    // idle, busy, seq codes never request
    step('1, all_trans(2'b00), 1'b1, "R1", g);
    check("R1 idle no grant", 32'(g | grant), 32'h0);
    step('1, all_trans(2'b01), 1'b1, "R1", g);
    step('1, all_trans(2'b11), 1'b1, "R1", g);
    // nonseq without select
    step('0, all_trans(2'b10), 1'b1, "R1", g);
    // only manager 3 qualifies
    t = all_trans(2'b11);
    t[7:6] = 2'b10;
    step('1, t, 1'b1, "R1", g);
    check("R1 only qualified manager", 32'(g), 32'h8);
    step('0, all_trans(2'b00), 1'b1, "R1", g);
  endtask

  task automatic t_priority;
    logic [N-1:0] g;
    // pointer is after manager 3 -> 4; request 1 and 2: wrap gives 1
    step(5'b00110, all_trans(2'b10), 1'b1, "R3", g);
    check("R3 cyclic scan from pointer", 32'(g), 32'h2);
    // pointer now 2; request 0 and 4 -> 4 wins
    step(5'b10001, all_trans(2'b10), 1'b1, "R3", g);
    check("R3 scan passes over idle", 32'(g), 32'h10);
    // pointer wraps to 0 (R10)
    step(5'b10001, all_trans(2'b10), 1'b1, "R10", g);
    check("R10 wrap to manager 0", 32'(g), 32'h1);
    step('0, all_trans(2'b00), 1'b1, "R3", g);
  endtask

  task automatic t_stall;
    logic [N-1:0] g;
    logic [N-1:0] own_before;
    // pointer at 1; manager 2 wins and takes the data phase
    step(5'b00100, all_trans(2'b10), 1'b1, "R4", g);
    own_before = own_m;
    // subordinate waits: owner and pointer hold, others keep being offered same grant
    step(5'b00011, all_trans(2'b10), 1'b0, "R6", g);
    step(5'b00011, all_trans(2'b10), 1'b0, "R6", g);
    @(negedge clk);
    check("R6 owner held through wait", 32'(grant_owner), 32'(own_before));
    // pointer held at 3: requests 0,1 -> 0 wins
    step(5'b00011, all_trans(2'b10), 1'b1, "R4", g);
    check("R4 pointer held while waited", 32'(g), 32'h1);
    step(5'b00011, all_trans(2'b10), 1'b1, "R4", g);
    check("R4 pointer moved after winner", 32'(g), 32'h2);
    step('0, all_trans(2'b00), 1'b1, "R8", g);
    step('0, all_trans(2'b00), 1'b1, "R8", g);
  endtask

  task automatic t_fair;
    logic [N-1:0] g;
    int wait_cnt [N];
    int worst;
    for (int i = 0; i < N; i++) wait_cnt[i] = 0;
    worst = 0;
    for (int c = 0; c < 6 * N; c++) begin
      logic r;
      r = (c % 4) != 3;
      step('1, all_trans(2'b10), r, "R5", g);
      if (sub_ready_in === 1'b1 || own_m == g) begin
        for (int i = 0; i < N; i++) begin
          if (g[i]) wait_cnt[i] = 0;
          else if (g != '0) wait_cnt[i]++;
          if (wait_cnt[i] > worst) worst = wait_cnt[i];
        end
      end
    end
    check("R5 max other grants while waiting", 32'(worst <= N - 1), 32'h1);
    step('0, all_trans(2'b00), 1'b1, "R5", g);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    t_qualify();
    t_priority();
    t_stall();
    t_fair();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule